// File: doc/BRIEF.md
# Hardware Random Number Sampler

This block turns a free-running stream of noise bits into 32-bit random words that software fetches through a small register port. Each accepted noise bit can pass through a configurable conditioning chain before it is packed. The chain has four settings: the bit is used unconditioned, it is stirred through a 32-bit Galois shift-register mixer, it is de-biased by a pair-based corrector, or it goes through the mixer and then the corrector.

Software writes a control register to choose the conditioning chain, switch bit acceptance on or off, and optionally replace the external noise with an internal deterministic generator for repeatable test output. A status register reports when a complete word is waiting. Reading the data register hands that word over and rearms the collector for the next 32 conditioned bits.

The register port is a plain single-cycle interface. Read data is combinational from the word address. Only a read strobe on the data address has a side effect.

Top module: `rng_sampler`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0 and the data register reads 0.
- R2: The control register sits at word address 0. It keeps only bits 11:8: bits 9:8 are the conditioning select, bit 10 is accept-enable and bit 11 is test mode. Every other bit reads back as 0.
- R3: While control bit 10 is 0, no noise bit is taken: the collector does not advance and no word becomes ready.
- R4: With select 0, the word is 32 consecutive accepted samples, and the earliest sample lands in bit 31.
- R5: Status (word address 2) bit 0 is 1 exactly when a complete word is waiting in the data register (word address 1). Address 3 reads 0.
- R6: A read strobe on the data address clears status bit 0. Bits that arrive while a word is waiting are dropped, so the next word holds only the 32 conditioned bits collected after that read.
- R7: With select 1, each accepted bit b updates the mixer state s to (s>>1) ^ (0x80200003 if s[0]^b else 0), and the low bit of the new state is emitted. The mixer state starts at 0x00000001 after reset and advances only while the mixer is in the chain.
- R8: With select 2, accepted bits are taken in pairs. The pair (0 then 1) emits 0, the pair (1 then 0) emits 1, and equal pairs emit nothing.
- R9: With select 3, the mixer output feeds the pair corrector.
- R10: With control bit 11 set, the noise input is ignored. Each accepted sample is the low bit of an internal generator that starts at 0xACE12B57 after reset and steps with the R7 rule using a zero input bit. The words that result are identical for any noise pattern.
- R11: A control write that changes bits 9:8 discards the partly built word, empties the corrector pair and clears status bit 0. A control write that leaves bits 9:8 unchanged does neither.
- R12: While a word is waiting, the data register does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| noise_bit | input | 1 | Free-running noise bit sampled each cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on data address only) |
| reg_addr | input | 2 | Word address: 0 control, 1 data, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |

## Verification
The hardest states to reach from the ports are a corrector pair that is half full at the moment the select changes, and conditioned bits that arrive while a word is still waiting to be read. The first comes from the mixer path, where emission depends on 32 bits of hidden state. The second is only visible in the contents of the next word. The bench runs a cycle-accurate reference of the whole chain next to the design and sweeps every select with test mode on and off over several noise patterns. It then changes the select in the middle of a word and keeps feeding bits across a pending word before the read, so both of these situations occur at known points and each word is checked against the reference.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int LFSR_W = 32;
  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_DATA = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd2;

  localparam int CTRL_SEL_LO = 8;
  localparam int CTRL_EN     = 10;
  localparam int CTRL_TEST   = 11;

  typedef enum logic [1:0] {
    COND_RAW   = 2'd0,
    COND_MIX   = 2'd1,
    COND_PAIR  = 2'd2,
    COND_CHAIN = 2'd3
  } cond_sel_e;

  // One Galois step with an injected bit.
  function automatic logic [LFSR_W-1:0] galois_step(
    input logic [LFSR_W-1:0] s,
    input logic              din,
    input logic [LFSR_W-1:0] poly
  );
    logic fb;
    fb = s[0] ^ din;
    return (s >> 1) ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/rng_galois.sv
module rng_galois
  import rng_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 32'h0000_0001,
  parameter logic [LFSR_W-1:0] POLY = 32'h8020_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              din,
  output logic [LFSR_W-1:0] state_o,
  output logic [LFSR_W-1:0] next_o
);
  logic [LFSR_W-1:0] st_q;

  assign next_o  = galois_step(st_q, din, POLY);
  assign state_o = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    st_q <= SEED;
    else if (step) st_q <= next_o;
  end
endmodule

// File: rtl/rng_whitener.sv
module rng_whitener (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic in_vld,
  input  logic in_bit,
  output logic out_vld,
  output logic out_bit,
  output logic have_o
);
  logic have_q, first_q;

  assign out_vld = in_vld && have_q && (first_q != in_bit);
  assign out_bit = first_q;
  assign have_o  = have_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      first_q <= 1'b0;
    end else if (flush) begin
      have_q  <= 1'b0;
    end else if (in_vld) begin
      if (!have_q) begin
        have_q  <= 1'b1;
        first_q <= in_bit;
      end else begin
        have_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rng_packer.sv
module rng_packer #(
  parameter int WORD_W = 32,
  localparam int CW    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_vld,
  input  logic              in_bit,
  input  logic              consume,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic [CW-1:0]     fill_o
);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, data_q;
  logic [CW-1:0]     cnt_q;
  logic              valid_q;
  logic [WORD_W-1:0] sh_nx;

  assign sh_nx   = {sh_q[WORD_W-2:0], in_bit};
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign fill_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (flush) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (consume) valid_q <= 1'b0;
      if (in_vld && !valid_q) begin
        sh_q <= sh_nx;
        if (cnt_q == LAST) begin
          data_q  <= sh_nx;
          valid_q <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rng_sampler.sv
module rng_sampler
  import rng_pkg::*;
#(
  parameter int                WORD_W    = 32,
  parameter logic [LFSR_W-1:0] POLY      = 32'h8020_0003,
  parameter logic [LFSR_W-1:0] MIX_SEED  = 32'h0000_0001,
  parameter logic [LFSR_W-1:0] TEST_SEED = 32'hACE1_2B57
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              noise_bit,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata
);
  localparam int CW = $clog2(WORD_W);

  cond_sel_e sel_q;
  logic      en_q, test_q;

  logic ctrl_wr, consume, sel_chg;
  logic [1:0] new_sel;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign consume = reg_rd && (reg_addr == ADDR_DATA);
  assign new_sel = reg_wdata[CTRL_SEL_LO+1:CTRL_SEL_LO];
  assign sel_chg = ctrl_wr && (new_sel != sel_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= COND_RAW;
      en_q   <= 1'b0;
      test_q <= 1'b0;
    end else if (ctrl_wr) begin
      sel_q  <= cond_sel_e'(new_sel);
      en_q   <= reg_wdata[CTRL_EN];
      test_q <= reg_wdata[CTRL_TEST];
    end
  end

  // Source selection: external noise or internal deterministic generator.
  logic [LFSR_W-1:0] tst_state, tst_next;
  logic              src_bit;

  rng_galois #(.SEED(TEST_SEED), .POLY(POLY)) tst_gen_i (
    .clk(clk), .rst_n(rst_n), .step(en_q && test_q), .din(1'b0),
    .state_o(tst_state), .next_o(tst_next)
  );

  assign src_bit = test_q ? tst_state[0] : noise_bit;

  // Stage 1: mixer.
  logic [LFSR_W-1:0] mix_state, mix_next;
  logic              st1_bit;

  rng_galois #(.SEED(MIX_SEED), .POLY(POLY)) mixer_i (
    .clk(clk), .rst_n(rst_n), .step(en_q && sel_q[0]), .din(src_bit),
    .state_o(mix_state), .next_o(mix_next)
  );

  assign st1_bit = sel_q[0] ? mix_next[0] : src_bit;

  // Stage 2: pair corrector.
  logic wh_in_vld, wh_out_vld, wh_out_bit, wh_have;
  logic st2_vld, st2_bit;

  assign wh_in_vld = en_q && sel_q[1];

  rng_whitener whiten_i (
    .clk(clk), .rst_n(rst_n), .flush(sel_chg),
    .in_vld(wh_in_vld), .in_bit(st1_bit),
    .out_vld(wh_out_vld), .out_bit(wh_out_bit), .have_o(wh_have)
  );

  assign st2_vld = sel_q[1] ? wh_out_vld : en_q;
  assign st2_bit = sel_q[1] ? wh_out_bit : st1_bit;

  // Word assembly.
  logic              word_valid;
  logic [WORD_W-1:0] word_data;
  logic [CW-1:0]     word_fill;

  rng_packer #(.WORD_W(WORD_W)) packer_i (
    .clk(clk), .rst_n(rst_n), .flush(sel_chg),
    .in_vld(st2_vld), .in_bit(st2_bit), .consume(consume),
    .valid_o(word_valid), .data_o(word_data), .fill_o(word_fill)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[CTRL_SEL_LO+1:CTRL_SEL_LO] = sel_q;
        reg_rdata[CTRL_EN]   = en_q;
        reg_rdata[CTRL_TEST] = test_q;
      end
      ADDR_DATA: reg_rdata = word_data;
      ADDR_STAT: reg_rdata[0] = word_valid;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rng_sampler_chk.sv
module rng_sampler_chk #(
  parameter int  WORD_W = 32,
  localparam int CW     = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_wr,
  input logic [1:0]        new_sel,
  input logic              consume,
  input logic              en_q,
  input logic [1:0]        sel_q,
  input logic              valid,
  input logic [WORD_W-1:0] data,
  input logic [CW-1:0]     fill,
  input logic              wh_have,
  input logic              wh_out_vld
);
  // R6: a read of a waiting word clears the ready flag
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && valid) |=> !valid);

  // R11: a select change empties the collector and drops the ready flag
  p_sel_change_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (new_sel != sel_q)) |=> (!valid && fill == '0 && !wh_have));

  // R3: with acceptance off, the fill level cannot move
  p_idle_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ctrl_wr) |=> $stable(fill));

  // R12: a waiting word holds still
  p_data_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> $stable(data));

  // R5: ready only after the last bit of a full word
  p_full_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> ($past(fill) == CW'(WORD_W - 1) && fill == '0));

  // R8: an emission closes a pair, so two emissions never follow back to back
  p_pair_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wh_out_vld |=> (!wh_out_vld && !wh_have));
endmodule

bind rng_sampler rng_sampler_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .new_sel(new_sel),
  .consume(consume), .en_q(en_q), .sel_q(sel_q), .valid(word_valid),
  .data(word_data), .fill(word_fill), .wh_have(wh_have),
  .wh_out_vld(wh_out_vld)
);

// File: tb/rng_sampler_tb_top.sv
`timescale 1ns/1ps
module rng_sampler_tb_top;
  localparam logic [31:0] POLY  = 32'h8020_0003;
  localparam logic [31:0] MSEED = 32'h0000_0001;
  localparam logic [31:0] TSEED = 32'hACE1_2B57;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic noise_bit = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int failures = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  rng_sampler dut_i (
    .clk(clk), .rst_n(rst_n), .noise_bit(noise_bit), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // Reference model state
  logic [3:0]  m_ctrl;      // {test, en, sel[1:0]}
  logic [31:0] m_tst, m_mix, m_sh, m_data;
  logic        m_have, m_first, m_valid;
  int          m_cnt;
  logic [31:0] nz;

  function automatic logic [31:0] ref_step(input logic [31:0] s, input logic d);
    logic [31:0] n;
    logic fb;
    fb = s[0] ^ d;
    for (int i = 0; i < 32; i++)
      n[i] = ((i < 31) ? s[i+1] : 1'b0) ^ (fb & POLY[i]);
    return n;
  endfunction

  function logic next_noise();
    nz = nz ^ (nz << 13);
    nz = nz ^ (nz >> 17);
    nz = nz ^ (nz << 5);
    return nz[3];
  endfunction

  function automatic logic [31:0] ref_read(input logic [1:0] a);
    case (a)
      2'd0: return {20'd0, m_ctrl, 8'd0};
      2'd1: return m_data;
      2'd2: return {31'd0, m_valid};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_edge(input logic nb, input logic wr, input logic rd,
                            input logic [1:0] a, input logic [31:0] wd);
    logic s, b, v, chg, nv;
    chg = wr && a == 2'd0 && wd[9:8] != m_ctrl[1:0];
    v = 1'b0; b = 1'b0;
    if (m_ctrl[2]) begin
      s = m_ctrl[3] ? m_tst[0] : nb;
      if (m_ctrl[3]) m_tst = ref_step(m_tst, 1'b0);
      b = s; v = 1'b1;
      if (m_ctrl[0]) begin m_mix = ref_step(m_mix, s); b = m_mix[0]; end
      if (m_ctrl[1]) begin
        if (!m_have) begin m_have = 1'b1; m_first = b; v = 1'b0; end
        else begin m_have = 1'b0; v = (m_first != b); b = m_first; end
      end
    end
    if (chg) begin
      m_cnt = 0; m_valid = 1'b0; m_have = 1'b0;
    end else begin
      nv = m_valid;
      if (rd && a == 2'd1) nv = 1'b0;
      if (v && !m_valid) begin
        m_sh = {m_sh[30:0], b};
        if (m_cnt == 31) begin m_data = m_sh; nv = 1'b1; m_cnt = 0; end
        else m_cnt++;
      end
      m_valid = nv;
    end
    if (wr && a == 2'd0) m_ctrl = wd[11:8];
  endtask

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // One cycle: drive at negedge, optionally compare, then advance the model.
  task automatic tick(input logic nb, input logic wr, input logic rd,
                      input logic [1:0] a, input logic [31:0] wd,
                      input logic do_chk, input string rq);
    @(negedge clk);
    noise_bit = nb; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    #1;
    if (do_chk) check(rq, reg_rdata, ref_read(a));
    model_edge(nb, wr, rd, a, wd);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_ctrl = '0; m_tst = TSEED; m_mix = MSEED; m_sh = '0; m_data = '0;
    m_have = 1'b0; m_first = 1'b0; m_valid = 1'b0; m_cnt = 0;
  endtask

  function automatic logic [31:0] ctl(input logic tm, input logic en, input logic [1:0] sel);
    return {20'd0, tm, en, sel, 8'd0};
  endfunction

  task automatic run_until_ready(input string rq);
    for (int i = 0; i < 800 && !m_valid; i++) tick(next_noise(), 0, 0, 2'd2, '0, 1, rq);
    if (!m_valid) begin failures++; $display("FAIL %s actual=no word expected=word", rq); end
  endtask

  logic [31:0] tword [4];

  initial begin
    string rq;
    logic [31:0] held;
    nz = 32'h1357_9BDF;
    do_reset();
    // R1: reset values
    tick(0, 0, 0, 2'd0, '0, 1, "R1");
    tick(0, 0, 0, 2'd2, '0, 1, "R1");
    tick(0, 0, 0, 2'd1, '0, 1, "R1");
    // R2: control keeps bits 11:8 only; R5: address 3 reads zero
    tick(0, 1, 0, 2'd0, 32'hFFFF_FFFF, 0, "");
    tick(0, 0, 0, 2'd0, '0, 1, "R2");
    check("R2", reg_rdata, 32'h0000_0F00);
    tick(0, 0, 0, 2'd3, '0, 1, "R5");

    // Sweep: every select, test mode off/on, two noise patterns
    for (int sel = 0; sel < 4; sel++) begin
      for (int tm = 0; tm < 2; tm++) begin
        for (int sd = 0; sd < 2; sd++) begin
          rq = tm ? "R10" : (sel == 0 ? "R4" : sel == 1 ? "R7" : sel == 2 ? "R8" : "R9");
          do_reset();
          nz = 32'hA5A5_0001 + 32'(sd) * 32'h0001_9E37 + 32'(sel) * 32'h77;
          tick(0, 1, 0, 2'd0, ctl(tm[0], 1'b1, sel[1:0]), 0, "");
          run_until_ready(rq);
          tick(next_noise(), 0, 1, 2'd1, '0, 1, rq);
          if (tm == 1) begin
            if (sd == 0) tword[sel] = m_data;
            else check("R10", m_data, tword[sel]);
          end
          tick(next_noise(), 0, 0, 2'd2, '0, 1, "R6");
        end
      end
    end

    // R3: acceptance off, then on
    do_reset();
    tick(0, 1, 0, 2'd0, ctl(0, 0, 2'd0), 0, "");
    for (int i = 0; i < 100; i++) tick(next_noise(), 0, 0, 2'd2, '0, 1, "R3");
    tick(0, 1, 0, 2'd0, ctl(0, 1, 2'd0), 0, "");
    run_until_ready("R3");
    tick(0, 0, 0, 2'd1, '0, 1, "R3");

    // R6 / R12: bits while a word waits are dropped, data stays
    do_reset();
    tick(0, 1, 0, 2'd0, ctl(0, 1, 2'd0), 0, "");
    run_until_ready("R5");
    held = m_data;
    for (int i = 0; i < 20; i++) tick(next_noise(), 0, 0, 2'd1, '0, 1, "R12");
    check("R12", reg_rdata, held);
    tick(next_noise(), 0, 1, 2'd1, '0, 1, "R6");
    tick(next_noise(), 0, 0, 2'd2, '0, 1, "R6");
    run_until_ready("R6");
    tick(0, 0, 0, 2'd1, '0, 1, "R6");

    // R11: select change mid-word, same-select write, change with word waiting
    do_reset();
    tick(0, 1, 0, 2'd0, ctl(0, 1, 2'd2), 0, "");
    for (int i = 0; i < 21; i++) tick(next_noise(), 0, 0, 2'd2, '0, 1, "R11");
    tick(next_noise(), 1, 0, 2'd0, ctl(0, 1, 2'd1), 0, "");
    run_until_ready("R11");
    tick(0, 0, 0, 2'd1, '0, 1, "R11");
    tick(next_noise(), 1, 0, 2'd0, ctl(1, 1, 2'd1), 0, "");
    tick(0, 0, 0, 2'd2, '0, 1, "R11");
    check("R11", reg_rdata, 32'd1);
    tick(next_noise(), 1, 0, 2'd0, ctl(0, 1, 2'd3), 0, "");
    tick(0, 0, 0, 2'd2, '0, 1, "R11");
    check("R11", reg_rdata, 32'd0);
    run_until_ready("R11");
    tick(0, 0, 0, 2'd1, '0, 1, "R11");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule